// File: doc/BRIEF.md
# Address Match Breakpoint Unit

This block watches the instruction fetch address and the current load/store access of a processor pipeline and compares both, in parallel, against the compare value of every hardware trigger. Each trigger has a control word and a compare word. Both come from a trigger register bank outside this block. The block also takes the current privilege level and a flag that is high while the hart runs a guest under virtualization.

A trigger fires when three things hold. It must be armed. The access kind it watches must occur (execute, read or write). The address must fall in its watch window. When any trigger fires, the unit registers a breakpoint-exception request for the pipeline to take before the instruction retires or the access commits. With the request it reports the lowest-numbered firing trigger and whether that trigger fired on the fetch.

The privilege filter depends on the trigger kind. Kind 2 triggers are silenced as soon as virtualization is on. Kind 6 triggers switch to a separate pair of guest-privilege enables in that mode.

Top module: `brk_match_unit`

## Requirements
- R1: A trigger can fire only when at least one of its privilege enables (control bits 3, 4, 6, and for kind 6 also 23, 24) is set and at least one of its access bits (bit 0 load, bit 1 store, bit 2 execute) is set.
- R2: An execute hit needs control bit 2 set, a valid fetch, and a fetch address exactly equal to the compare word. Such a hit sets the execute flag output.
- R3: A data hit needs a valid access whose direction has its bit set: bit 0 for a read (write flag 0) or bit 1 for a write (write flag 1). The accessed bytes must also overlap the trigger's window.
- R4: Outside virtualization, the trigger is gated by control bit 3+priv, where priv is the level code: 0 user, 1 supervisor, 3 machine.
- R5: In virtualization, a kind 6 trigger is gated by bit 23 for priv 0 and by bit 24 for priv 1. Bits 3..6 are then ignored, and priv 2 or 3 never matches.
- R6: A kind 2 trigger never fires while virtualization is on, whatever its enables.
- R7: A size code of 0, or a code with no defined length, gives an 8-byte window that starts at the compare word.
- R8: Size codes 1, 2 and 3 give windows of 1, 2 and 4 bytes, and kind 6 code 5 gives 8 bytes. The size code sits in bits 17:16 for kind 2 (extended by bits 22:21 when XLEN is 64) and in bits 19:16 for kind 6. An access covers 2^size bytes from its address.
- R9: When several triggers fire in one cycle, a single request is raised and the lowest index is reported.
- R10: The kind is held in the top four control bits. A trigger whose kind is neither 2 nor 6 never fires.
- R11: Request, index and execute flag are registered: they follow the inputs of the previous clock cycle. Without a request, the index and the flag read zero. All three read zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_ctrl_i | input | NUM_TRIG*XLEN | Control words, trigger n in slice n |
| trig_cmp_i | input | NUM_TRIG*XLEN | Compare words, trigger n in slice n |
| priv_i | input | 2 | Current privilege level code |
| virt_i | input | 1 | Virtualization mode active |
| fetch_valid_i | input | 1 | A fetch address is presented |
| fetch_pc_i | input | XLEN | Fetch address |
| mem_valid_i | input | 1 | A data access is presented |
| mem_addr_i | input | XLEN | Data access byte address |
| mem_size_i | input | 2 | log2 of access length in bytes |
| mem_write_i | input | 1 | 1 for a write, 0 for a read |
| brk_req_o | output | 1 | Breakpoint exception request |
| brk_idx_o | output | IDX_W | Index of the reported trigger |
| brk_exec_o | output | 1 | Reported trigger hit on the fetch |

## Verification
The bench builds the unit with NUM_TRIG = 4 and XLEN = 32. Four triggers allow the priority test to place simultaneous hits in slots 1 and 3 and to mix a data hit in slot 0 with an execute hit in slot 2. The 32-bit width puts the kind field at bits 31:28 and leaves kind 2 with a two-bit size code, so every defined window length and the unsupported-code fallback can be reached with small addresses. Window edges are checked one byte inside and one byte outside on both sides.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int KIND_W = 4;
    localparam logic [KIND_W-1:0] KIND_MATCH2 = 4'd2;
    localparam logic [KIND_W-1:0] KIND_MATCH6 = 4'd6;

    // access-kind bits of the control word
    localparam int CB_LOAD  = 0;
    localparam int CB_STORE = 1;
    localparam int CB_EXEC  = 2;

    // privilege enables: base + level code
    localparam int CB_PRIV_U  = 3;
    localparam int CB_PRIV_S  = 4;
    localparam int CB_PRIV_M  = 6;
    localparam int CB_GUEST_U = 23;
    localparam int CB_GUEST_S = 24;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_RSVD  = 2'd2,
        LVL_MACH  = 2'd3
    } lvl_e;

    // window length in bytes for a size code; undefined codes watch 8 bytes
    function automatic logic [3:0] window_bytes(input logic [3:0] code);
        logic [3:0] len;
        case (code)
            4'd1:    len = 4'd1;
            4'd2:    len = 4'd2;
            4'd3:    len = 4'd4;
            4'd5:    len = 4'd8;
            default: len = 4'd8;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/brk_trig_eval.sv
module brk_trig_eval
    import brk_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] ctrl_i,
    input  logic [XLEN-1:0] cmp_i,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic            fetch_valid_i,
    input  logic [XLEN-1:0] fetch_pc_i,
    input  logic            mem_valid_i,
    input  logic [XLEN-1:0] mem_addr_i,
    input  logic [1:0]      mem_size_i,
    input  logic            mem_write_i,
    output logic            hit_exec_o,
    output logic            hit_data_o
);

    localparam int EXT_W = XLEN + 1;

    logic [KIND_W-1:0] kind;
    logic              is_k2;
    logic              is_k6;
    logic [3:0]        k2_code;
    logic [3:0]        size_code;
    logic              any_lvl_en;
    logic              any_acc_en;
    logic              lvl_ok;
    logic              armed;
    logic              dir_ok;
    logic              overlap;
    logic [EXT_W-1:0]  acc_lo;
    logic [EXT_W-1:0]  acc_hi;
    logic [EXT_W-1:0]  win_lo;
    logic [EXT_W-1:0]  win_hi;

    assign kind  = ctrl_i[XLEN-1 -: KIND_W];
    assign is_k2 = (kind == KIND_MATCH2);
    assign is_k6 = (kind == KIND_MATCH6);

    // kind 2 size code gains two upper bits only on the wide variant
    if (XLEN >= 64) begin : g_wide_size
        assign k2_code = {ctrl_i[22:21], ctrl_i[17:16]};
    end else begin : g_narrow_size
        assign k2_code = {2'b00, ctrl_i[17:16]};
    end

    assign size_code = is_k6 ? ctrl_i[19:16] : k2_code;

    always_comb begin
        any_lvl_en = ctrl_i[CB_PRIV_U] | ctrl_i[CB_PRIV_S] | ctrl_i[CB_PRIV_M];
        if (is_k6) begin
            any_lvl_en = any_lvl_en | ctrl_i[CB_GUEST_U] | ctrl_i[CB_GUEST_S];
        end
        any_acc_en = ctrl_i[CB_LOAD] | ctrl_i[CB_STORE] | ctrl_i[CB_EXEC];
    end

    always_comb begin
        lvl_ok = 1'b0;
        if (!virt_i) begin
            case (priv_i)
                LVL_USER:  lvl_ok = ctrl_i[CB_PRIV_U];
                LVL_SUPER: lvl_ok = ctrl_i[CB_PRIV_S];
                LVL_RSVD:  lvl_ok = ctrl_i[5];
                default:   lvl_ok = ctrl_i[CB_PRIV_M];
            endcase
        end else if (is_k6) begin
            case (priv_i)
                LVL_USER:  lvl_ok = ctrl_i[CB_GUEST_U];
                LVL_SUPER: lvl_ok = ctrl_i[CB_GUEST_S];
                default:   lvl_ok = 1'b0;
            endcase
        end
    end

    assign armed = (is_k2 | is_k6) & any_lvl_en & any_acc_en & lvl_ok;

    // byte ranges, one bit wider so the end address never wraps
    always_comb begin
        acc_lo  = {1'b0, mem_addr_i};
        acc_hi  = acc_lo + (EXT_W'(1) << mem_size_i);
        win_lo  = {1'b0, cmp_i};
        win_hi  = win_lo + EXT_W'(window_bytes(size_code));
        overlap = (acc_lo < win_hi) && (win_lo < acc_hi);
        dir_ok  = mem_write_i ? ctrl_i[CB_STORE] : ctrl_i[CB_LOAD];
    end

    assign hit_exec_o = armed & fetch_valid_i & ctrl_i[CB_EXEC] & (fetch_pc_i == cmp_i);
    assign hit_data_o = armed & mem_valid_i & dir_ok & overlap;

    always_comb begin
        if (virt_i && is_k2) begin
            p_k2_silent_virt_r6: assert (!hit_exec_o && !hit_data_o);
        end
        if (!is_k2 && !is_k6) begin
            p_foreign_kind_r10: assert (!hit_exec_o && !hit_data_o);
        end
        if (hit_exec_o) begin
            p_exec_exact_r2: assert (fetch_pc_i == cmp_i && fetch_valid_i);
        end
        if (hit_data_o) begin
            p_data_needs_access_r3: assert (mem_valid_i);
        end
    end

endmodule

// File: rtl/brk_prio_pick.sv
module brk_prio_pick #(
    parameter int N     = 2,
    parameter int IDX_W = 1
) (
    input  logic [N-1:0]     hits_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    logic [N-1:0] below;

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        any_o = |hits_i;
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            below[i] = (IDX_W'(i) < idx_o);
        end
        if (any_o) begin
            p_lowest_wins_r9: assert (hits_i[idx_o] && ((hits_i & below) == '0));
        end
    end

endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
    import brk_pkg::*;
#(
    parameter int NUM_TRIG = 2,
    parameter int XLEN     = 32,
    parameter int IDX_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_TRIG*XLEN-1:0] trig_ctrl_i,
    input  logic [NUM_TRIG*XLEN-1:0] trig_cmp_i,
    input  logic [1:0]               priv_i,
    input  logic                     virt_i,
    input  logic                     fetch_valid_i,
    input  logic [XLEN-1:0]          fetch_pc_i,
    input  logic                     mem_valid_i,
    input  logic [XLEN-1:0]          mem_addr_i,
    input  logic [1:0]               mem_size_i,
    input  logic                     mem_write_i,
    output logic                     brk_req_o,
    output logic [IDX_W-1:0]         brk_idx_o,
    output logic                     brk_exec_o
);

    typedef struct packed {
        logic             req;
        logic [IDX_W-1:0] idx;
        logic             exec;
    } brk_state_t;

    brk_state_t state_d, state_q;

    logic [NUM_TRIG-1:0] exec_vec;
    logic [NUM_TRIG-1:0] data_vec;
    logic [NUM_TRIG-1:0] hit_vec;
    logic                hit_any;
    logic [IDX_W-1:0]    hit_idx;

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
        brk_trig_eval #(
            .XLEN (XLEN)
        ) eval_i (
            .ctrl_i        (trig_ctrl_i[g*XLEN +: XLEN]),
            .cmp_i         (trig_cmp_i[g*XLEN +: XLEN]),
            .priv_i        (priv_i),
            .virt_i        (virt_i),
            .fetch_valid_i (fetch_valid_i),
            .fetch_pc_i    (fetch_pc_i),
            .mem_valid_i   (mem_valid_i),
            .mem_addr_i    (mem_addr_i),
            .mem_size_i    (mem_size_i),
            .mem_write_i   (mem_write_i),
            .hit_exec_o    (exec_vec[g]),
            .hit_data_o    (data_vec[g])
        );
    end

    assign hit_vec = exec_vec | data_vec;

    brk_prio_pick #(
        .N     (NUM_TRIG),
        .IDX_W (IDX_W)
    ) prio_i (
        .hits_i (hit_vec),
        .any_o  (hit_any),
        .idx_o  (hit_idx)
    );

    always_comb begin
        state_d      = '0;
        state_d.req  = hit_any;
        if (hit_any) begin
            state_d.idx  = hit_idx;
            state_d.exec = exec_vec[hit_idx];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign brk_req_o  = state_q.req;
    assign brk_idx_o  = state_q.idx;
    assign brk_exec_o = state_q.exec;

    p_req_follows_hit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|hit_vec) |=> brk_req_o);

    p_no_spurious_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|hit_vec) |=> (!brk_req_o && brk_idx_o == '0 && !brk_exec_o));

    p_exec_flag_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_exec_o |-> brk_req_o);

    p_single_lowest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_vec[0] |=> (brk_idx_o == '0));

endmodule

// File: tb/brk_match_unit_tb_top.sv
module brk_match_unit_tb_top;

    localparam int CLK_P = 10;
    localparam int NT    = 4;
    localparam int XW    = 32;
    localparam int IW    = 2;

    localparam logic [XW-1:0] F_LD = 32'h1;
    localparam logic [XW-1:0] F_ST = 32'h2;
    localparam logic [XW-1:0] F_EX = 32'h4;
    localparam logic [XW-1:0] F_U  = 32'h8;
    localparam logic [XW-1:0] F_S  = 32'h10;
    localparam logic [XW-1:0] F_M  = 32'h40;
    localparam logic [XW-1:0] F_VU = 32'h0080_0000;
    localparam logic [XW-1:0] F_VS = 32'h0100_0000;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic [XW-1:0] t_ctrl [NT];
    logic [XW-1:0] t_cmp  [NT];
    logic [NT*XW-1:0] ctrl_flat, cmp_flat;
    logic [1:0]  priv;
    logic        virt, fv, mv, wr;
    logic [XW-1:0] pc, addr;
    logic [1:0]  msz;
    logic        req, ex;
    logic [IW-1:0] idx;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NT; i++) begin
            ctrl_flat[i*XW +: XW] = t_ctrl[i];
            cmp_flat[i*XW +: XW]  = t_cmp[i];
        end
    end

    brk_match_unit #(.NUM_TRIG(NT), .XLEN(XW)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni),
        .trig_ctrl_i(ctrl_flat), .trig_cmp_i(cmp_flat),
        .priv_i(priv), .virt_i(virt),
        .fetch_valid_i(fv), .fetch_pc_i(pc),
        .mem_valid_i(mv), .mem_addr_i(addr), .mem_size_i(msz), .mem_write_i(wr),
        .brk_req_o(req), .brk_idx_o(idx), .brk_exec_o(ex)
    );

    function automatic logic [XW-1:0] mk(input logic [3:0] k, input logic [XW-1:0] f);
        return {k, {(XW-4){1'b0}}} | f;
    endfunction

    function automatic logic [XW-1:0] sz(input logic [3:0] c);
        return XW'(c) << 16;
    endfunction

    task automatic chk(input string tag, input logic e_req, input logic [IW-1:0] e_idx, input logic e_ex);
        total++;
        if (req !== e_req || idx !== e_idx || ex !== e_ex) begin
            bad++;
            $display("FAIL %s: req/idx/exec got %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, req, idx, ex, e_req, e_idx, e_ex);
        end
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < NT; i++) begin
            t_ctrl[i] = '0;
            t_cmp[i]  = '0;
        end
    endtask

    // present one cycle of stimulus; registered result is sampled after the edge
    task automatic drive(input logic f, input logic [XW-1:0] p, input logic m,
                         input logic [XW-1:0] a, input logic [1:0] s, input logic w,
                         input logic [1:0] pr, input logic v);
        @(negedge clk);
        fv = f; pc = p; mv = m; addr = a; msz = s; wr = w; priv = pr; virt = v;
        @(posedge clk);
        #1;
    endtask

    task automatic fetch(input logic [XW-1:0] p, input logic [1:0] pr, input logic v);
        drive(1'b1, p, 1'b0, '0, 2'd0, 1'b0, pr, v);
    endtask

    task automatic access(input logic [XW-1:0] a, input logic [1:0] s, input logic w);
        drive(1'b0, '0, 1'b1, a, s, w, 2'd3, 1'b0);
    endtask

    task automatic t_reset();
        clear_cfg();
        t_ctrl[0] = mk(4'd2, F_M | F_EX);
        t_cmp[0]  = 32'h100;
        fv = 1'b1; pc = 32'h100; mv = 1'b0; addr = '0; msz = '0; wr = 1'b0;
        priv = 2'd3; virt = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 outputs zero in reset despite match", 1'b0, '0, 1'b0);
        @(negedge clk);
        fv = 1'b0;
        rst_ni = 1'b1;
    endtask

    task automatic t_exec();
        clear_cfg();
        t_ctrl[0] = mk(4'd2, F_M | F_EX);
        t_cmp[0]  = 32'h1000;
        fetch(32'h1000, 2'd3, 1'b0);
        chk("R2 exact fetch match", 1'b1, 2'd0, 1'b1);
        fetch(32'h1001, 2'd3, 1'b0);
        chk("R2 fetch off by one", 1'b0, '0, 1'b0);
    endtask

    task automatic t_enable();
        clear_cfg();
        t_ctrl[1] = mk(4'd2, F_EX);
        t_cmp[1]  = 32'h1200;
        fetch(32'h1200, 2'd3, 1'b0);
        chk("R1 no privilege enable", 1'b0, '0, 1'b0);
        t_ctrl[1] = mk(4'd2, F_M | F_U | F_S);
        fetch(32'h1200, 2'd3, 1'b0);
        chk("R1 no access bit", 1'b0, '0, 1'b0);
    endtask

    task automatic t_direction();
        clear_cfg();
        t_ctrl[2] = mk(4'd2, F_M | F_LD | sz(4'd3));
        t_cmp[2]  = 32'h2000;
        access(32'h2000, 2'd2, 1'b0);
        chk("R3 read hits load trigger", 1'b1, 2'd2, 1'b0);
        access(32'h2000, 2'd2, 1'b1);
        chk("R3 write ignored by load trigger", 1'b0, '0, 1'b0);
        t_ctrl[2] = mk(4'd2, F_M | F_ST | sz(4'd3));
        access(32'h2000, 2'd2, 1'b1);
        chk("R3 write hits store trigger", 1'b1, 2'd2, 1'b0);
        access(32'h2000, 2'd2, 1'b0);
        chk("R3 read ignored by store trigger", 1'b0, '0, 1'b0);
    endtask

    task automatic t_priv();
        clear_cfg();
        t_ctrl[0] = mk(4'd2, F_U | F_EX);
        t_cmp[0]  = 32'h800;
        fetch(32'h800, 2'd0, 1'b0);
        chk("R4 user bit at user level", 1'b1, 2'd0, 1'b1);
        fetch(32'h800, 2'd1, 1'b0);
        chk("R4 user bit at supervisor level", 1'b0, '0, 1'b0);
        fetch(32'h800, 2'd3, 1'b0);
        chk("R4 user bit at machine level", 1'b0, '0, 1'b0);
        t_ctrl[0] = mk(4'd2, F_S | F_EX);
        fetch(32'h800, 2'd1, 1'b0);
        chk("R4 supervisor bit", 1'b1, 2'd0, 1'b1);
        t_ctrl[0] = mk(4'd2, F_M | F_EX);
        fetch(32'h800, 2'd3, 1'b0);
        chk("R4 machine bit", 1'b1, 2'd0, 1'b1);
    endtask

    task automatic t_guest();
        clear_cfg();
        t_ctrl[3] = mk(4'd6, F_VS | F_EX);
        t_cmp[3]  = 32'h900;
        fetch(32'h900, 2'd1, 1'b1);
        chk("R5 guest supervisor enable", 1'b1, 2'd3, 1'b1);
        fetch(32'h900, 2'd0, 1'b1);
        chk("R5 guest user not enabled", 1'b0, '0, 1'b0);
        fetch(32'h900, 2'd1, 1'b0);
        chk("R5 guest bit unused outside virt", 1'b0, '0, 1'b0);
        t_ctrl[3] = mk(4'd6, F_U | F_EX);
        fetch(32'h900, 2'd0, 1'b1);
        chk("R5 host user bit ignored in virt", 1'b0, '0, 1'b0);
        t_ctrl[3] = mk(4'd6, F_VU | F_EX);
        fetch(32'h900, 2'd0, 1'b1);
        chk("R5 guest user enable", 1'b1, 2'd3, 1'b1);
    endtask

    task automatic t_k2_virt();
        clear_cfg();
        t_ctrl[1] = mk(4'd2, F_U | F_S | F_M | F_EX);
        t_cmp[1]  = 32'hA00;
        fetch(32'hA00, 2'd1, 1'b1);
        chk("R6 kind 2 silent in virt", 1'b0, '0, 1'b0);
        fetch(32'hA00, 2'd1, 1'b0);
        chk("R6 kind 2 fires outside virt", 1'b1, 2'd1, 1'b1);
    endtask

    task automatic t_any_size();
        clear_cfg();
        t_ctrl[0] = mk(4'd2, F_M | F_LD);
        t_cmp[0]  = 32'h3000;
        access(32'h3007, 2'd0, 1'b0);
        chk("R7 last byte of 8-byte window", 1'b1, 2'd0, 1'b0);
        access(32'h3008, 2'd0, 1'b0);
        chk("R7 byte past window", 1'b0, '0, 1'b0);
        access(32'h2FFD, 2'd2, 1'b0);
        chk("R7 word straddling window start", 1'b1, 2'd0, 1'b0);
        access(32'h2FFE, 2'd1, 1'b0);
        chk("R7 half below window", 1'b0, '0, 1'b0);
        t_ctrl[0] = mk(4'd6, F_M | F_LD | sz(4'd7));
        access(32'h3007, 2'd0, 1'b0);
        chk("R7 undefined code watches 8 bytes", 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_sized();
        clear_cfg();
        t_ctrl[2] = mk(4'd2, F_M | F_LD | sz(4'd1));
        t_cmp[2]  = 32'h4002;
        access(32'h4003, 2'd0, 1'b0);
        chk("R8 1-byte window next byte", 1'b0, '0, 1'b0);
        access(32'h4000, 2'd2, 1'b0);
        chk("R8 word covering 1-byte window", 1'b1, 2'd2, 1'b0);
        t_ctrl[2] = mk(4'd2, F_M | F_LD | sz(4'd2));
        access(32'h4003, 2'd0, 1'b0);
        chk("R8 2-byte window upper byte", 1'b1, 2'd2, 1'b0);
        access(32'h4004, 2'd0, 1'b0);
        chk("R8 2-byte window past end", 1'b0, '0, 1'b0);
        t_ctrl[2] = mk(4'd6, F_M | F_LD | sz(4'd5));
        t_cmp[2]  = 32'h5000;
        access(32'h5007, 2'd0, 1'b0);
        chk("R8 kind 6 code 5 last byte", 1'b1, 2'd2, 1'b0);
        access(32'h5008, 2'd0, 1'b0);
        chk("R8 kind 6 code 5 past end", 1'b0, '0, 1'b0);
    endtask

    task automatic t_prio();
        clear_cfg();
        t_ctrl[1] = mk(4'd2, F_M | F_EX);
        t_cmp[1]  = 32'h6000;
        t_ctrl[3] = mk(4'd6, F_M | F_EX);
        t_cmp[3]  = 32'h6000;
        fetch(32'h6000, 2'd3, 1'b0);
        chk("R9 slots 1 and 3 report 1", 1'b1, 2'd1, 1'b1);
        t_ctrl[1] = '0;
        fetch(32'h6000, 2'd3, 1'b0);
        chk("R9 slot 3 alone", 1'b1, 2'd3, 1'b1);
        clear_cfg();
        t_ctrl[0] = mk(4'd2, F_M | F_ST);
        t_cmp[0]  = 32'h7000;
        t_ctrl[2] = mk(4'd2, F_M | F_EX);
        t_cmp[2]  = 32'h7100;
        drive(1'b1, 32'h7100, 1'b1, 32'h7000, 2'd0, 1'b1, 2'd3, 1'b0);
        chk("R9 data slot 0 beats exec slot 2", 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_kind();
        clear_cfg();
        t_ctrl[0] = mk(4'd3, F_M | F_EX);
        t_cmp[0]  = 32'hB00;
        t_ctrl[1] = mk(4'd0, F_M | F_EX);
        t_cmp[1]  = 32'hB00;
        t_ctrl[2] = mk(4'd15, F_M | F_EX);
        t_cmp[2]  = 32'hB00;
        fetch(32'hB00, 2'd3, 1'b0);
        chk("R10 foreign kinds never fire", 1'b0, '0, 1'b0);
    endtask

    task automatic t_latency();
        clear_cfg();
        t_ctrl[1] = mk(4'd6, F_M | F_EX);
        t_cmp[1]  = 32'hC00;
        @(negedge clk);
        fv = 1'b1; pc = 32'hC00; mv = 1'b0; priv = 2'd3; virt = 1'b0;
        #1;
        chk("R11 no change before edge", 1'b0, '0, 1'b0);
        @(posedge clk);
        #1;
        chk("R11 request after edge", 1'b1, 2'd1, 1'b1);
        drive(1'b0, 32'hC00, 1'b0, '0, 2'd0, 1'b0, 2'd3, 1'b0);
        chk("R11 request drops with idle cycle", 1'b0, '0, 1'b0);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_exec();
        t_enable();
        t_direction();
        t_priv();
        t_guest();
        t_k2_virt();
        t_any_size();
        t_sized();
        t_prio();
        t_kind();
        t_latency();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule